// File: doc/BRIEF.md
# Two-Channel Address Breakpoint Comparator

This block watches the bus cycles of a processor and raises a break request when one of them matches a programmed address and access kind. There are two identical channels, numbered 0 and 1. Each channel holds a 24-bit break address and an 8-bit control register, both on a small byte-wide register bus. A channel can ignore a number of low address bits before it compares. It accepts only one kind of cycle: instruction fetch, data read, data write, or any data access. It can also be limited to cycles in which the CPU owns the bus.

A match latches a sticky flag in that channel. Software clears the flag in two steps: it reads the control register and sees the flag at 1, then writes a 0 to the flag bit. If the flag was not seen set before the write, the write does not clear it, so a match that arrives between the read and the write of a read-modify-write is kept. Each channel drives a level interrupt request.

The bus side is a plain one-cycle strobe. The block has no back-pressure: it samples every cycle in which `bus_valid` is high, and the watched bus is never stalled. The register bus is also plain. A write takes effect at the clock edge, and read data is combinational from the current register state.

Top module: `brk_unit`

## Requirements
- R1: After reset every register reads 0x00 and `brk_irq` is 0.
- R2: Register index map on `reg_addr`: 0 is the channel 0 control register and 1 is the channel 1 control register. Indices 2, 3 and 4 are channel 0 address bits [7:0], [15:8] and [23:16]. Indices 5, 6 and 7 are the same three bytes of channel 1. Every written byte reads back unchanged, except that control bit 7 reads back the flag.
- R3: Control bits [5:3] are the mask code. Codes 0 to 7 leave out the lowest 0, 1, 2, 3, 4, 8, 12 or 16 address bits from the comparison. All other bits must be equal for a match.
- R4: Control bits [2:1] select the cycle kind. A fetch cycle is `bus_fetch`=1. A data read is `bus_fetch`=0 with `bus_write`=0. A data write is `bus_fetch`=0 with `bus_write`=1. The codes are 0 = fetch only, 1 = data read only, 2 = data write only, 3 = any data read or write.
- R5: Control bit 6 qualifies the bus owner. When it is 0, a cycle with `bus_alt_master`=1 never matches. When it is 1, both owners can match.
- R6: A matching strobe sets control bit 7 (the flag) at the next clock edge. The flag stays set until it is cleared. It never sets without a strobe.
- R7: A read of the control register that returns the flag as 1 arms that channel. A later control write with bit 7 = 0 then clears the flag and disarms the channel. A write of 1 to bit 7 never clears the flag and leaves the arming unchanged. A write of 0 to bit 7 with no prior arming read leaves the flag set.
- R8: When a clear write and a matching strobe fall in the same cycle, the flag stays set. The arming is used up, so a second write of 0 needs a new read first.
- R9: `brk_irq[n]` is a level equal to the channel n flag AND control bit 0 (interrupt enable).
- R10: The two channels are independent. A strobe, a write or a read that targets one channel never changes the flag, arming or registers of the other channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 3 | Register index |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (arms a clear) |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data, combinational |
| bus_valid | input | 1 | One-cycle strobe of a watched bus cycle |
| bus_addr | input | 24 | Address of the watched cycle |
| bus_write | input | 1 | Watched cycle is a write |
| bus_fetch | input | 1 | Watched cycle is an instruction fetch |
| bus_alt_master | input | 1 | Watched cycle is owned by the non-CPU master |
| brk_irq | output | 2 | Per-channel break request level |

## Verification
A software clear write and a matching bus strobe can land in the same clock cycle. So can an arming read and a write of the same control register. Directed tests first arm a channel by reading the flag as 1. They then issue the 0-write together with a strobe that matches, and check that the flag survives and that a bare second 0-write does not clear it. Constrained random cycles mix reads, writes and strobes on both channels in the same cycles. Every result is judged against a bench model that follows the stated priority: match over clear, write over arming read.

// File: rtl/brk_pkg.sv
package brk_pkg;

  localparam int NUM_CH     = 2;
  localparam int CTRL_W     = 8;
  localparam int CTRL_SLOTS = NUM_CH;

  // control byte bit positions (software decodes these)
  localparam int B_FLAG = 7;
  localparam int B_ANY  = 6;
  localparam int B_CODE = 3;
  localparam int B_CYC  = 1;
  localparam int B_IE   = 0;

  typedef enum logic [1:0] {
    CYC_FETCH = 2'b00,
    CYC_READ  = 2'b01,
    CYC_WRITE = 2'b10,
    CYC_DATA  = 2'b11
  } cyc_sel_e;

  typedef struct packed {
    logic       flag;
    logic       any_master;
    logic [2:0] mask_code;
    cyc_sel_e   cyc;
    logic       irq_en;
  } brk_ctrl_t;

  // number of low address bits left out of the compare for a mask code
  function automatic int unsigned ignored_bits(input logic [2:0] code);
    case (code)
      3'd5:    return 8;
      3'd6:    return 12;
      3'd7:    return 16;
      default: return int'(code);
    endcase
  endfunction

endpackage

// File: rtl/brk_mask_gen.sv
module brk_mask_gen
  import brk_pkg::*;
#(
  parameter int ADDR_W = 24
) (
  input  logic [2:0]        code,
  output logic [ADDR_W-1:0] care
);

  int unsigned skip;
  assign skip = ignored_bits(code);

  for (genvar i = 0; i < ADDR_W; i++) begin : g_bit
    assign care[i] = (32'(i) >= skip);
  end

endmodule

// File: rtl/brk_addr_match.sv
module brk_addr_match
  import brk_pkg::*;
#(
  parameter int ADDR_W = 24
) (
  input  logic              bus_valid,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_write,
  input  logic              bus_fetch,
  input  logic              bus_alt_master,
  input  logic [ADDR_W-1:0] brk_addr,
  input  logic              any_master,
  input  logic [2:0]        mask_code,
  input  cyc_sel_e          cyc,
  output logic              hit
);

  logic [ADDR_W-1:0] care;
  logic              addr_ok;
  logic              kind_ok;
  logic              owner_ok;

  brk_mask_gen #(.ADDR_W(ADDR_W)) u_mask (
    .code (mask_code),
    .care (care)
  );

  assign addr_ok  = ((bus_addr ^ brk_addr) & care) == '0;
  assign owner_ok = any_master | ~bus_alt_master;

  always_comb begin
    unique case (cyc)
      CYC_FETCH: kind_ok = bus_fetch;
      CYC_READ:  kind_ok = ~bus_fetch & ~bus_write;
      CYC_WRITE: kind_ok = ~bus_fetch &  bus_write;
      default:   kind_ok = ~bus_fetch;
    endcase
  end

  assign hit = bus_valid & addr_ok & kind_ok & owner_ok;

endmodule

// File: rtl/brk_channel.sv
module brk_channel
  import brk_pkg::*;
#(
  parameter int ADDR_W = 24
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                ctrl_wr,
  input  logic                ctrl_rd,
  input  logic [ADDR_W/8-1:0] byte_wr,
  input  logic [7:0]          wdata,
  input  logic                bus_valid,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic                bus_write,
  input  logic                bus_fetch,
  input  logic                bus_alt_master,
  output brk_ctrl_t           ctrl_q,
  output logic [ADDR_W-1:0]   baddr_q,
  output logic                irq
);

  localparam int NB = ADDR_W / 8;

  logic       flag_q;
  logic       armed_q;
  logic       any_q;
  logic [2:0] code_q;
  cyc_sel_e   cyc_q;
  logic       ie_q;
  logic       hit;
  logic       zero_wr;
  logic       clr_ok;

  brk_addr_match #(.ADDR_W(ADDR_W)) u_match (
    .bus_valid      (bus_valid),
    .bus_addr       (bus_addr),
    .bus_write      (bus_write),
    .bus_fetch      (bus_fetch),
    .bus_alt_master (bus_alt_master),
    .brk_addr       (baddr_q),
    .any_master     (any_q),
    .mask_code      (code_q),
    .cyc            (cyc_q),
    .hit            (hit)
  );

  // configuration fields
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      any_q  <= 1'b0;
      code_q <= 3'd0;
      cyc_q  <= CYC_FETCH;
      ie_q   <= 1'b0;
    end else if (ctrl_wr) begin
      any_q  <= wdata[B_ANY];
      code_q <= wdata[B_CODE +: 3];
      cyc_q  <= cyc_sel_e'(wdata[B_CYC +: 2]);
      ie_q   <= wdata[B_IE];
    end
  end

  // sticky flag and two-step clear
  assign zero_wr = ctrl_wr & ~wdata[B_FLAG];
  assign clr_ok  = zero_wr & armed_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q  <= 1'b0;
      armed_q <= 1'b0;
    end else begin
      if (hit)         flag_q <= 1'b1;
      else if (clr_ok) flag_q <= 1'b0;

      if (zero_wr)                armed_q <= 1'b0;
      else if (ctrl_rd && flag_q) armed_q <= 1'b1;
    end
  end

  // break address bytes
  for (genvar b = 0; b < NB; b++) begin : g_byte
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          baddr_q[b*8 +: 8] <= 8'h00;
      else if (byte_wr[b]) baddr_q[b*8 +: 8] <= wdata;
    end
  end

  assign ctrl_q = '{flag: flag_q, any_master: any_q, mask_code: code_q,
                    cyc: cyc_q, irq_en: ie_q};
  assign irq    = flag_q & ie_q;

endmodule

// File: rtl/brk_unit.sv
module brk_unit
  import brk_pkg::*;
#(
  parameter int ADDR_W = 24
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [2:0]               reg_addr,
  input  logic                     reg_wr,
  input  logic                     reg_rd,
  input  logic [7:0]               reg_wdata,
  output logic [7:0]               reg_rdata,
  input  logic                     bus_valid,
  input  logic [ADDR_W-1:0]        bus_addr,
  input  logic                     bus_write,
  input  logic                     bus_fetch,
  input  logic                     bus_alt_master,
  output logic [NUM_CH-1:0]        brk_irq
);

  localparam int NB     = ADDR_W / 8;
  localparam int NREG   = CTRL_SLOTS + NUM_CH * NB;
  localparam int REG_AW = $clog2(NREG);

  brk_ctrl_t         ch_ctrl    [NUM_CH];
  logic [ADDR_W-1:0] ch_baddr   [NUM_CH];
  logic [NB-1:0]     ch_byte_wr [NUM_CH];
  logic [NUM_CH-1:0] ch_ctrl_wr;
  logic [NUM_CH-1:0] ch_ctrl_rd;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    assign ch_ctrl_wr[c] = reg_wr && (reg_addr == REG_AW'(c));
    assign ch_ctrl_rd[c] = reg_rd && (reg_addr == REG_AW'(c));

    for (genvar b = 0; b < NB; b++) begin : g_dec
      assign ch_byte_wr[c][b] =
        reg_wr && (reg_addr == REG_AW'(CTRL_SLOTS + c*NB + b));
    end

    brk_channel #(.ADDR_W(ADDR_W)) u_ch (
      .clk            (clk),
      .rst_n          (rst_n),
      .ctrl_wr        (ch_ctrl_wr[c]),
      .ctrl_rd        (ch_ctrl_rd[c]),
      .byte_wr        (ch_byte_wr[c]),
      .wdata          (reg_wdata),
      .bus_valid      (bus_valid),
      .bus_addr       (bus_addr),
      .bus_write      (bus_write),
      .bus_fetch      (bus_fetch),
      .bus_alt_master (bus_alt_master),
      .ctrl_q         (ch_ctrl[c]),
      .baddr_q        (ch_baddr[c]),
      .irq            (brk_irq[c])
    );
  end

  always_comb begin
    reg_rdata = 8'h00;
    for (int c = 0; c < NUM_CH; c++) begin
      if (reg_addr == REG_AW'(c)) reg_rdata = ch_ctrl[c];
      for (int b = 0; b < NB; b++) begin
        if (reg_addr == REG_AW'(CTRL_SLOTS + c*NB + b))
          reg_rdata = ch_baddr[c][b*8 +: 8];
      end
    end
  end

endmodule

// File: rtl/brk_unit_chk.sv
module brk_unit_chk
  import brk_pkg::*;
#(
  parameter int REG_AW = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic [REG_AW-1:0] reg_addr,
  input logic              reg_wr,
  input logic [7:0]        reg_wdata,
  input logic              bus_valid,
  input logic              bus_fetch,
  input logic              bus_alt_master,
  input logic [NUM_CH-1:0] brk_irq,
  input brk_ctrl_t         ch_ctrl [NUM_CH]
);

  for (genvar c = 0; c < NUM_CH; c++) begin : g_chk

    // R6: the flag only rises after a bus strobe
    p_set_needs_strobe_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ch_ctrl[c].flag) |-> $past(bus_valid));

    // R4: fetch-only channel rises only on a fetch
    p_fetch_kind_r4: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(ch_ctrl[c].flag) && ($past(ch_ctrl[c].cyc) == CYC_FETCH))
        |-> $past(bus_fetch));

    // R4: data kinds never rise on a fetch
    p_data_kind_r4: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(ch_ctrl[c].flag) && ($past(ch_ctrl[c].cyc) != CYC_FETCH))
        |-> $past(!bus_fetch));

    // R5: CPU-only channel ignores the other master
    p_cpu_only_r5: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(ch_ctrl[c].flag) && $past(!ch_ctrl[c].any_master))
        |-> $past(!bus_alt_master));

    // R7: the flag falls only after a zero write to its control register
    p_clear_path_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(ch_ctrl[c].flag)
        |-> $past(reg_wr && (reg_addr == REG_AW'(c)) && !reg_wdata[7]));

    // R7: writing one to the flag bit keeps it set
    p_one_keeps_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && (reg_addr == REG_AW'(c)) && reg_wdata[7] && ch_ctrl[c].flag)
        |=> ch_ctrl[c].flag);

    // R9: a disabled channel never requests
    p_irq_gate_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !ch_ctrl[c].irq_en |-> !brk_irq[c]);
  end

endmodule

bind brk_unit brk_unit_chk #(.REG_AW(REG_AW)) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .reg_addr       (reg_addr),
  .reg_wr         (reg_wr),
  .reg_wdata      (reg_wdata),
  .bus_valid      (bus_valid),
  .bus_fetch      (bus_fetch),
  .bus_alt_master (bus_alt_master),
  .brk_irq        (brk_irq),
  .ch_ctrl        (ch_ctrl)
);

// File: tb/brk_unit_bench.sv
`timescale 1ns/1ps
module brk_unit_bench;

  localparam int AW = 24;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [2:0]    reg_addr = '0;
  logic          reg_wr = 1'b0, reg_rd = 1'b0;
  logic [7:0]    reg_wdata = '0;
  logic [7:0]    reg_rdata;
  logic          bus_valid = 1'b0, bus_write = 1'b0, bus_fetch = 1'b0;
  logic          bus_alt_master = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [1:0]    brk_irq;

  brk_unit #(.ADDR_W(AW)) u_brk_unit (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_rd(reg_rd), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .bus_valid(bus_valid), .bus_addr(bus_addr), .bus_write(bus_write),
    .bus_fetch(bus_fetch), .bus_alt_master(bus_alt_master), .brk_irq(brk_irq)
  );

  always #2 clk = ~clk;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;
  logic [7:0] last_rd;

  // reference model
  logic [6:0]    m_cfg  [2];
  logic          m_flag [2];
  logic          m_arm  [2];
  logic [AW-1:0] m_ba   [2];

  function automatic int ign(input logic [2:0] code);
    int t [8] = '{0, 1, 2, 3, 4, 8, 12, 16};
    return t[code];
  endfunction

  function automatic logic exp_hit(input int c);
    logic [AW-1:0] care;
    logic kind;
    care = ~((AW'(1) << ign(m_cfg[c][5:3])) - AW'(1));
    case (m_cfg[c][2:1])
      2'd0: kind = bus_fetch;
      2'd1: kind = !bus_fetch && !bus_write;
      2'd2: kind = !bus_fetch && bus_write;
      default: kind = !bus_fetch;
    endcase
    return bus_valid && (((bus_addr ^ m_ba[c]) & care) == '0) && kind
           && (m_cfg[c][6] || !bus_alt_master);
  endfunction

  function automatic logic [7:0] exp_rdata(input logic [2:0] a);
    int idx;
    if (a < 3'd2) return {m_flag[a[0]], m_cfg[a[0]]};
    idx = int'(a) - 2;
    return m_ba[idx / 3][(idx % 3)*8 +: 8];
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic op(input logic rd, input logic wr, input logic [2:0] a,
                    input logic [7:0] wd, input logic bv, input logic [AW-1:0] ba,
                    input logic bw, input logic bf, input logic bm, input string tag);
    logic nf [2];
    logic na [2];
    reg_rd = rd; reg_wr = wr; reg_addr = a; reg_wdata = wd;
    bus_valid = bv; bus_addr = ba; bus_write = bw; bus_fetch = bf; bus_alt_master = bm;
    #1;
    if (rd) begin
      last_rd = reg_rdata;
      chk({tag, " rdata"}, reg_rdata, exp_rdata(a));
    end
    for (int c = 0; c < 2; c++) begin
      logic cw;
      cw = wr && (a == 3'(c));
      nf[c] = exp_hit(c) || (m_flag[c] && !(cw && !wd[7] && m_arm[c]));
      na[c] = (cw && !wd[7]) ? 1'b0 : ((rd && a == 3'(c) && m_flag[c]) ? 1'b1 : m_arm[c]);
    end
    @(posedge clk);
    for (int c = 0; c < 2; c++) begin
      m_flag[c] = nf[c];
      m_arm[c]  = na[c];
      if (wr && a == 3'(c)) m_cfg[c] = wd[6:0];
    end
    if (wr && a >= 3'd2) begin
      int idx;
      idx = int'(a) - 2;
      m_ba[idx / 3][(idx % 3)*8 +: 8] = wd;
    end
    @(negedge clk);
    reg_rd = 0; reg_wr = 0; bus_valid = 0;
    chk({tag, " irq"}, brk_irq, {m_flag[1] & m_cfg[1][0], m_flag[0] & m_cfg[0][0]});
  endtask

  task automatic wr_reg(input logic [2:0] a, input logic [7:0] d, input string tag);
    op(0, 1, a, d, 0, '0, 0, 0, 0, tag);
  endtask
  task automatic rd_reg(input logic [2:0] a, input string tag);
    op(1, 0, a, 8'h00, 0, '0, 0, 0, 0, tag);
  endtask
  task automatic strobe(input logic [AW-1:0] ad, input logic w, input logic f,
                        input logic m, input string tag);
    op(0, 0, 3'd0, 8'h00, 1, ad, w, f, m, tag);
  endtask
  task automatic set_ba(input int c, input logic [AW-1:0] v);
    for (int b = 0; b < 3; b++) wr_reg(3'(2 + c*3 + b), v[b*8 +: 8], "R2 set");
  endtask
  task automatic flag_is(input int c, input logic e, input string tag);
    rd_reg(3'(c), tag);
    chk({tag, " flag"}, last_rd[7], e);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog act=running exp=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  localparam logic [AW-1:0] BA0 = 24'hA5C3E1;
  localparam logic [AW-1:0] BA1 = 24'h3C5A96;

  initial begin
    void'($urandom(32'd4711));
    for (int c = 0; c < 2; c++) begin
      m_cfg[c] = '0; m_flag[c] = 0; m_arm[c] = 0; m_ba[c] = '0;
    end
    repeat (3) @(negedge clk);
    // R1: reset state
    for (int a = 0; a < 8; a++) begin
      reg_addr = 3'(a); #1;
      chk("R1 reset rdata", reg_rdata, 8'h00);
    end
    chk("R1 reset irq", brk_irq, 2'b00);
    rst_n = 1'b1;
    @(negedge clk);

    // R2: register map
    wr_reg(3'd2, 8'h12, "R2"); wr_reg(3'd3, 8'h34, "R2"); wr_reg(3'd4, 8'h56, "R2");
    rd_reg(3'd4, "R2 hi byte"); chk("R2 hi literal", last_rd, 8'h56);
    rd_reg(3'd2, "R2 lo byte"); chk("R2 lo literal", last_rd, 8'h12);
    wr_reg(3'd1, 8'h7F, "R2"); rd_reg(3'd1, "R2 ctrl"); chk("R2 ctrl literal", last_rd, 8'h7F);
    rd_reg(3'd6, "R2 other ch"); chk("R2 ch1 byte untouched", last_rd, 8'h00);
    wr_reg(3'd1, 8'h00, "R2");

    // R3: mask codes
    set_ba(0, BA0);
    for (int k = 0; k < 8; k++) begin
      int w;
      w = ign(3'(k));
      wr_reg(3'd0, 8'(k << 3), "R3 cfg");
      strobe(BA0 ^ (AW'(1) << w), 0, 1, 0, "R3 miss");
      flag_is(0, 1'b0, "R3 first kept bit");
      strobe(BA0 ^ ((AW'(1) << w) - AW'(1)), 0, 1, 0, "R3 hit");
      flag_is(0, 1'b1, "R3 ignored bits");
      wr_reg(3'd0, 8'(k << 3), "R3 clear");
      flag_is(0, 1'b0, "R3 cleared");
    end

    // R4: cycle kinds
    for (int s = 0; s < 4; s++) begin
      wr_reg(3'd0, 8'(s << 1), "R4 cfg");
      for (int t = 0; t < 3; t++) begin
        logic e;
        e = (s == 0) ? (t == 0) : (s == 1) ? (t == 1) : (s == 2) ? (t == 2) : (t != 0);
        strobe(BA0, t == 2, t == 0, 0, "R4 strobe");
        flag_is(0, e, "R4 kind");
        if (e) wr_reg(3'd0, 8'(s << 1), "R4 clear");
      end
    end

    // R5: bus owner
    wr_reg(3'd0, 8'h00, "R5 cfg");
    strobe(BA0, 0, 1, 1, "R5 alt"); flag_is(0, 1'b0, "R5 cpu-only alt");
    strobe(BA0, 0, 1, 0, "R5 cpu"); flag_is(0, 1'b1, "R5 cpu-only cpu");
    wr_reg(3'd0, 8'h40, "R5 cfg any");
    strobe(BA0, 0, 1, 1, "R5 any alt"); flag_is(0, 1'b1, "R5 any alt");

    // R7: two-step clear
    wr_reg(3'd0, 8'h00, "R7 write0 armed");
    flag_is(0, 1'b0, "R7 armed clear");
    strobe(BA0, 0, 1, 0, "R7 set");
    wr_reg(3'd0, 8'h00, "R7 bare zero");
    flag_is(0, 1'b1, "R7 no read no clear");
    wr_reg(3'd0, 8'h80, "R7 one");
    flag_is(0, 1'b1, "R7 write one kept");
    wr_reg(3'd0, 8'h00, "R7 zero after read");
    flag_is(0, 1'b0, "R7 cleared");

    // R8: collision of clear and match
    strobe(BA0, 0, 1, 0, "R8 set");
    rd_reg(3'd0, "R8 arm");
    op(0, 1, 3'd0, 8'h00, 1, BA0, 0, 1, 0, "R8 collide");
    wr_reg(3'd0, 8'h00, "R8 disarmed zero");
    flag_is(0, 1'b1, "R8 match wins");
    wr_reg(3'd0, 8'h00, "R8 rearmed zero");
    flag_is(0, 1'b0, "R8 clear after rearm");

    // R9 / R6 / R10
    set_ba(1, BA1);
    wr_reg(3'd0, 8'h01, "R9 ie");
    wr_reg(3'd1, 8'h01, "R10 ie");
    strobe(BA1, 0, 1, 0, "R10 ch1 hit");
    chk("R10 ch0 quiet", brk_irq, 2'b10);
    strobe(BA0, 0, 1, 0, "R6 ch0 hit");
    chk("R6 flag next edge", brk_irq, 2'b11);
    op(0, 0, 3'd0, 8'h00, 0, '0, 0, 0, 0, "R6 idle");
    chk("R6 sticky", brk_irq, 2'b11);
    wr_reg(3'd0, 8'h80, "R9 ie off");
    chk("R9 gated", brk_irq, 2'b10);
    wr_reg(3'd0, 8'h81, "R9 ie on");
    chk("R9 level", brk_irq, 2'b11);
    rd_reg(3'd1, "R10 arm ch1");
    wr_reg(3'd1, 8'h01, "R10 clear ch1");
    chk("R10 ch0 kept", brk_irq, 2'b01);

    // random mix (R6 R7 R8 R9 R10)
    for (int i = 0; i < 5000; i++) begin
      logic rd, wr, bv;
      logic [2:0] a;
      logic [7:0] wd;
      logic [AW-1:0] ad;
      int c;
      rd = ($urandom_range(0, 9) < 3);
      wr = ($urandom_range(0, 9) < 2);
      a  = 3'($urandom_range(0, 7));
      if ($urandom_range(0, 3) != 0) a = 3'($urandom_range(0, 1));
      wd = 8'($urandom);
      if ($urandom_range(0, 1) == 1) wd[7] = 1'b0;
      bv = ($urandom_range(0, 1) == 1);
      c  = $urandom_range(0, 1);
      ad = m_ba[c] ^ (AW'($urandom) & ((AW'(1) << $urandom_range(0, 18)) - AW'(1)));
      op(rd, wr, a, wd, bv, ad, 1'($urandom), 1'($urandom), 1'($urandom),
         "random R6 R8 R10");
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule